// File: doc/BRIEF.md
# Four-Bit Adaptive Delta Sample Decoder

This block turns a stream of 4-bit adaptive differential codes into 8-bit audio samples, one sample per accepted code. Each code carries a sign bit (bit 3) and a three-bit magnitude (bits 2:0). The block looks up a step size from a 49-entry table, using its current step index. It scales that step by the magnitude and adds the signed result to a running accumulator. It then moves the step index up or down so that the next code is quantized more coarsely or more finely.

A producer presents a code together with a one-cycle valid strobe. One clock later the block raises its own valid strobe for one cycle, with the new sample registered on the output. A synchronous clear input returns the decoder to its starting state between streams. The asynchronous reset does the same. Sample-rate pacing and conversion to an analog level are left to the surrounding logic.

Top module: `adpcm_nibble_decoder`

## Requirements
- R1: After reset, `sample` is 0 and `sampleValid` is 0. The accumulator and the step index both start at zero.
- R2: A code accepted on a clock edge (`codeValid` high and `clear` low) makes `sampleValid` high for exactly the following cycle, with the new sample on `sample` in that cycle. When no code is accepted, `sampleValid` is low in the next cycle.
- R3: The delta for a code of magnitude m (bits 2:0) at step size S is floor((2·m+1)·S/8). It is subtracted instead of added when code bit 3 is 1.
- R4: Step sizes are indexed 0..48 and rise from 16 at index 0 (then 17, 19, 21, ...) to 1411 at index 47 and 1552 at index 48.
- R5: After each code the step index moves by −1 for magnitudes 0 to 3, and by +2, +5, +7, +9 for magnitudes 4, 5, 6, 7. The result is then held within 0..48.
- R6: The accumulator is updated as follows. If the sum of the old value and the delta lies in 0..2047, it is kept unchanged. Otherwise the sum keeps its low 12 bits and has 4096 subtracted, so the stored value always lies in −4096..2047.
- R7: `sample` is the low 8 bits of the accumulator arithmetically shifted right by 8. Its top three bits are therefore always equal.
- R8: `clear` high on a clock edge zeroes the accumulator, the step index and `sample`, and holds `sampleValid` low in the next cycle. It takes priority over a code presented on the same edge.
- R9: While `codeValid` is low, the value on `code` has no effect, and `sample` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous return to the starting state |
| codeValid | input | 1 | Strobe: `code` is to be decoded on this edge |
| code | input | 4 | Sign bit 3, magnitude bits 2:0 |
| sampleValid | output | 1 | High for one cycle when a new sample is presented |
| sample | output | 8 | Decoded sample, two's complement |

## Verification
The assertions check the handshake timing, the clear priority, the holding of the sample while idle, and the sign-replicated shape of the output byte on every cycle. The arithmetic cannot be judged from a single cycle: the delta scaling, the step table values, the step-index clamping at both ends and the folding of the accumulator only show up as differences in long sample sequences. The bench drives runs of large and small magnitudes to push the index against 48 and 0, and compares every sample with an independent model.

// File: rtl/adpcm_pkg.sv
package adpcm_pkg;

  // Code layout: bit 3 is sign, bits 2:0 magnitude
  localparam int CODE_W   = 4;
  localparam int MAG_W    = CODE_W - 1;
  localparam int STEP_W   = 11;
  localparam int STEP_CNT = 49;
  localparam int IDX_W    = $clog2(STEP_CNT);
  localparam int ADJ_W    = 5;

  typedef struct packed {
    logic load;   // decode the presented code
    logic wipe;   // return to starting state
  } ctrl_strobes_t;

  // Step size for a given table position
  function automatic logic [STEP_W-1:0] stepSize(input logic [IDX_W-1:0] idx);
    case (idx)
      6'd0:  stepSize = 11'd16;   6'd1:  stepSize = 11'd17;
      6'd2:  stepSize = 11'd19;   6'd3:  stepSize = 11'd21;
      6'd4:  stepSize = 11'd23;   6'd5:  stepSize = 11'd25;
      6'd6:  stepSize = 11'd28;   6'd7:  stepSize = 11'd31;
      6'd8:  stepSize = 11'd34;   6'd9:  stepSize = 11'd37;
      6'd10: stepSize = 11'd41;   6'd11: stepSize = 11'd45;
      6'd12: stepSize = 11'd50;   6'd13: stepSize = 11'd55;
      6'd14: stepSize = 11'd60;   6'd15: stepSize = 11'd66;
      6'd16: stepSize = 11'd73;   6'd17: stepSize = 11'd80;
      6'd18: stepSize = 11'd88;   6'd19: stepSize = 11'd97;
      6'd20: stepSize = 11'd107;  6'd21: stepSize = 11'd118;
      6'd22: stepSize = 11'd130;  6'd23: stepSize = 11'd143;
      6'd24: stepSize = 11'd157;  6'd25: stepSize = 11'd173;
      6'd26: stepSize = 11'd190;  6'd27: stepSize = 11'd209;
      6'd28: stepSize = 11'd230;  6'd29: stepSize = 11'd253;
      6'd30: stepSize = 11'd279;  6'd31: stepSize = 11'd307;
      6'd32: stepSize = 11'd337;  6'd33: stepSize = 11'd371;
      6'd34: stepSize = 11'd408;  6'd35: stepSize = 11'd449;
      6'd36: stepSize = 11'd494;  6'd37: stepSize = 11'd544;
      6'd38: stepSize = 11'd598;  6'd39: stepSize = 11'd658;
      6'd40: stepSize = 11'd724;  6'd41: stepSize = 11'd796;
      6'd42: stepSize = 11'd876;  6'd43: stepSize = 11'd963;
      6'd44: stepSize = 11'd1060; 6'd45: stepSize = 11'd1166;
      6'd46: stepSize = 11'd1282; 6'd47: stepSize = 11'd1411;
      6'd48: stepSize = 11'd1552;
      default: stepSize = 11'd1552;
    endcase
  endfunction

  // Index movement for a code magnitude
  function automatic logic signed [ADJ_W-1:0] indexMove(input logic [MAG_W-1:0] mag);
    case (mag)
      3'd4:    indexMove = 5'sd2;
      3'd5:    indexMove = 5'sd5;
      3'd6:    indexMove = 5'sd7;
      3'd7:    indexMove = 5'sd9;
      default: indexMove = -5'sd1;
    endcase
  endfunction

endpackage

// File: rtl/adpcm_delta_unit.sv
module adpcm_delta_unit
  import adpcm_pkg::*;
#(
  parameter int FRAC_SHIFT = 3,
  parameter int DELTA_W    = STEP_W + MAG_W + 1 - FRAC_SHIFT + 1
) (
  input  logic [STEP_W-1:0]         step,
  input  logic [CODE_W-1:0]         code,
  output logic signed [DELTA_W-1:0] delta
);
  localparam int ODD_W  = MAG_W + 1;
  localparam int PROD_W = STEP_W + ODD_W;

  logic [ODD_W-1:0]  oddFactor;
  logic [PROD_W-1:0] partial [ODD_W];
  logic [PROD_W-1:0] product;
  logic [DELTA_W-1:0] magnitude;

  assign oddFactor = {code[MAG_W-1:0], 1'b1};

  // shift-and-add constant multiplier
  for (genvar i = 0; i < ODD_W; i++) begin : g_part
    assign partial[i] = oddFactor[i] ? (PROD_W'(step) << i) : '0;
  end

  always_comb begin
    product = '0;
    for (int i = 0; i < ODD_W; i++) product = product + partial[i];
  end

  assign magnitude = DELTA_W'(product >> FRAC_SHIFT);
  assign delta     = code[CODE_W-1] ? -$signed(magnitude) : $signed(magnitude);

endmodule

// File: rtl/adpcm_control.sv
module adpcm_control
  import adpcm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          codeValid,
  output ctrl_strobes_t strobes,
  output logic          sampleValid
);
  always_comb begin
    strobes.wipe = clear;
    strobes.load = codeValid & ~clear;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sampleValid <= 1'b0;
    else        sampleValid <= strobes.load;
  end
endmodule

// File: rtl/adpcm_datapath.sv
module adpcm_datapath
  import adpcm_pkg::*;
#(
  parameter int ACC_W     = 12,
  parameter int OUT_W     = 8,
  parameter int OUT_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_strobes_t     strobes,
  input  logic [CODE_W-1:0] code,
  output logic [OUT_W-1:0]  sample
);
  localparam int STATE_W = ACC_W + 1;
  localparam int SUM_W   = ACC_W + 2;
  localparam int DELTA_W = STEP_W + MAG_W + 1 - 3 + 1;
  localparam int ISUM_W  = IDX_W + 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STEP_CNT - 1);

  logic signed [STATE_W-1:0] accQ, accNext;
  logic [IDX_W-1:0]          idxQ, idxNext;
  logic signed [DELTA_W-1:0] delta;
  logic signed [SUM_W-1:0]   sum;
  logic signed [ISUM_W-1:0]  idxSum;
  logic [STEP_W-1:0]         step;

  assign step = stepSize(idxQ);

  adpcm_delta_unit #(.FRAC_SHIFT(3), .DELTA_W(DELTA_W)) u_delta (
    .step (step),
    .code (code),
    .delta(delta)
  );

  // fold: non-negative small sums kept, others forced negative
  always_comb begin
    sum = SUM_W'(accQ) + SUM_W'(delta);
    if (sum[SUM_W-1:ACC_W-1] == '0) accNext = {1'b0, sum[ACC_W-1:0]};
    else                            accNext = {1'b1, sum[ACC_W-1:0]};
  end

  always_comb begin
    idxSum = $signed({2'b00, idxQ}) + ISUM_W'(indexMove(code[MAG_W-1:0]));
    if (idxSum < 0)                               idxNext = '0;
    else if (idxSum > $signed({2'b00, LAST_IDX})) idxNext = LAST_IDX;
    else                                          idxNext = idxSum[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accQ   <= '0;
      idxQ   <= '0;
      sample <= '0;
    end else if (strobes.wipe) begin
      accQ   <= '0;
      idxQ   <= '0;
      sample <= '0;
    end else if (strobes.load) begin
      accQ   <= accNext;
      idxQ   <= idxNext;
      sample <= OUT_W'(accNext >>> OUT_SHIFT);
    end
  end
endmodule

// File: rtl/adpcm_nibble_decoder.sv
module adpcm_nibble_decoder
  import adpcm_pkg::*;
#(
  parameter int ACC_W     = 12,
  parameter int OUT_W     = 8,
  parameter int OUT_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              codeValid,
  input  logic [CODE_W-1:0] code,
  output logic              sampleValid,
  output logic [OUT_W-1:0]  sample
);
  ctrl_strobes_t strobes;

  adpcm_control u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .codeValid  (codeValid),
    .strobes    (strobes),
    .sampleValid(sampleValid)
  );

  adpcm_datapath #(.ACC_W(ACC_W), .OUT_W(OUT_W), .OUT_SHIFT(OUT_SHIFT)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobes(strobes),
    .code   (code),
    .sample (sample)
  );
endmodule

// File: rtl/adpcm_checker.sv
module adpcm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       clear,
  input logic       codeValid,
  input logic       sampleValid,
  input logic [7:0] sample
);
  // R2: accepted code gives valid next cycle
  a_r2_valid_after_code: assert property (@(posedge clk) disable iff (!rst_n)
    (codeValid && !clear) |=> sampleValid);

  // R2: no accepted code, no valid
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (!codeValid || clear) |=> !sampleValid);

  // R8: clear zeroes the output
  a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (sample == 8'h00));

  // R9: idle leaves the sample alone
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!codeValid && !clear) |=> $stable(sample));

  // R7: top three bits replicate the sign
  a_r7_sign_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (sample[7:5] == 3'b000) || (sample[7:5] == 3'b111));
endmodule

bind adpcm_nibble_decoder adpcm_checker u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .clear      (clear),
  .codeValid  (codeValid),
  .sampleValid(sampleValid),
  .sample     (sample)
);

// File: tb/test_adpcm_nibble_decoder.sv
`timescale 1ns/1ps
module test_adpcm_nibble_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear = 1'b0;
  logic       codeValid = 1'b0;
  logic [3:0] code = 4'h0;
  logic       sampleValid;
  logic [7:0] sample;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  adpcm_nibble_decoder i_adpcm_nibble_decoder (
    .clk(clk), .rst_n(rst_n), .clear(clear), .codeValid(codeValid),
    .code(code), .sampleValid(sampleValid), .sample(sample)
  );

  localparam int STEPS [49] = '{
    16, 17, 19, 21, 23, 25, 28, 31, 34, 37, 41, 45, 50, 55, 60, 66, 73, 80,
    88, 97, 107, 118, 130, 143, 157, 173, 190, 209, 230, 253, 279, 307, 337,
    371, 408, 449, 494, 544, 598, 658, 724, 796, 876, 963, 1060, 1166, 1282,
    1411, 1552};

  localparam logic [3:0] VEC [32] = '{
    4'h7, 4'h7, 4'h7, 4'h7, 4'h7, 4'hF, 4'hF, 4'hF,
    4'h4, 4'h5, 4'h6, 4'hC, 4'hD, 4'hE, 4'h0, 4'h1,
    4'h2, 4'h3, 4'h8, 4'h9, 4'hA, 4'hB, 4'h7, 4'h7,
    4'h7, 4'h7, 4'h7, 4'h7, 4'h7, 4'h7, 4'hF, 4'h0};

  int mAcc = 0;
  int mIdx = 0;

  // independent reference arithmetic (R3..R7)
  task automatic modelStep(input logic [3:0] c, output int expSample);
    int mag, d, mv;
    mag = int'(c[2:0]);
    d = ((2 * mag + 1) * STEPS[mIdx]) / 8;
    if (c[3]) d = -d;
    mAcc = mAcc + d;
    if ((mAcc & ~32'h7ff) != 0) mAcc = mAcc | ~32'hfff;
    else                        mAcc = mAcc & 32'hfff;
    case (mag)
      4: mv = 2; 5: mv = 5; 6: mv = 7; 7: mv = 9; default: mv = -1;
    endcase
    mIdx = mIdx + mv;
    if (mIdx < 0) mIdx = 0;
    if (mIdx > 48) mIdx = 48;
    expSample = (mAcc >>> 8) & 255;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendCode(input logic [3:0] c, input string req);
    int e;
    @(negedge clk);
    codeValid = 1'b1; code = c;
    modelStep(c, e);
    @(negedge clk);
    codeValid = 1'b0; code = ~c;
    check({req, " valid"}, int'(sampleValid), 1);
    check({req, " sample"}, int'(sample), e);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int e;
    int prevExp;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset sample", int'(sample), 0);
    check("R1 reset valid", int'(sampleValid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset valid", int'(sampleValid), 0);

    // vector table, streamed back to back (R2 R3 R4 R5 R6 R7)
    prevExp = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check("R2 stream valid", int'(sampleValid), 1);
        check("R6 stream sample", int'(sample), prevExp);
      end
      codeValid = 1'b1; code = VEC[i];
      modelStep(VEC[i], e);
      prevExp = e;
    end
    @(negedge clk);
    codeValid = 1'b0;
    check("R2 stream last valid", int'(sampleValid), 1);
    check("R7 stream last sample", int'(sample), prevExp);

    // R2 R9: idle cycle, garbage code ignored
    @(negedge clk);
    code = 4'h7;
    check("R2 idle valid low", int'(sampleValid), 0);
    check("R9 idle sample held", int'(sample), prevExp);
    @(negedge clk);
    check("R9 idle sample held 2", int'(sample), prevExp);

    // R5 R4: push index to top clamp then beyond
    for (int i = 0; i < 20; i++) sendCode(4'h7, "R5 top clamp");
    for (int i = 0; i < 6; i++) sendCode(4'hF, "R4 max step negative");
    for (int i = 0; i < 6; i++) sendCode(4'h7, "R6 fold large");
    // R5: bottom clamp
    for (int i = 0; i < 60; i++) sendCode(4'h0, "R5 bottom clamp");
    sendCode(4'h3, "R3 small step");
    sendCode(4'hB, "R3 small step negative");

    // R8: clear zeroes state
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    mAcc = 0; mIdx = 0;
    check("R8 clear sample", int'(sample), 0);
    check("R8 clear valid", int'(sampleValid), 0);
    sendCode(4'h7, "R8 after clear");

    // R8: clear beats simultaneous code
    @(negedge clk);
    clear = 1'b1; codeValid = 1'b1; code = 4'h7;
    @(negedge clk);
    clear = 1'b0; codeValid = 1'b0;
    mAcc = 0; mIdx = 0;
    check("R8 priority valid", int'(sampleValid), 0);
    check("R8 priority sample", int'(sample), 0);
    sendCode(4'h6, "R8 priority after");

    // random runs biased toward both clamp limits
    for (int r = 0; r < 40; r++) begin
      logic [3:0] base;
      base = $urandom_range(15, 0);
      for (int k = 0; k < 25; k++) begin
        logic [3:0] c;
        if (r % 3 == 0)      c = {base[3], 3'b111};
        else if (r % 3 == 1) c = {base[3], 2'b00, base[0]};
        else                 c = 4'($urandom_range(15, 0));
        sendCode(c, "R6 random");
      end
    end

    // R1: reset mid-stream
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 async reset sample", int'(sample), 0);
    check("R1 async reset valid", int'(sampleValid), 0);
    rst_n = 1'b1;
    mAcc = 0; mIdx = 0;
    sendCode(4'h5, "R1 restart");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule